// File: doc/BRIEF.md
# Distributed Contiguous-Group CTA Scheduler

This block hands out the thread-block (CTA) indices of one kernel to compute units (SMs) spread over several modules. When a kernel is launched it cuts the index range `0 .. count-1` into one contiguous chunk per module, with sizes as equal as possible. Each module then issues its own chunk in ascending order, one CTA per cycle, to whichever of its SMs is free. The same index therefore always lands in the same module when the same kernel is launched again. This keeps data locality inside the module.

A mode bit, sampled with the launch, selects the baseline policy instead. In that mode one global scheduler issues one CTA per cycle to any free SM, using a rotating priority over all SMs, with no regard to module boundaries. Each SM holds at most one CTA. A per-SM completion pulse frees the SM. When the whole range has been issued and every CTA has completed, the block pulses `kernel_done`. A launch that arrives while a kernel is still running waits until the scheduler is idle again.

Top module: `cta_group_sched`

## Requirements
- R1: While reset is held and after its release, `launch_ready` is 1, `gnt_vld` is all zero and `kernel_done` is 0.
- R2: In group mode (`launch_mode`=0), let base = count / NUM_MOD and rem = count % NUM_MOD. Module m receives exactly len = base + (m < rem ? 1 : 0) CTAs, with indices first .. first+len-1, where first = m*base + min(m, rem). Module m's grants appear on lane m (`gnt_vld[m]`, `gnt_sm[m*SW +: SW]`, `gnt_cta[m*CNT_W +: CNT_W]`).
- R3: In group mode each lane issues at most one grant per cycle. A lane grants whenever its chunk is not exhausted and at least one of its SMs is eligible. Its indices come out in ascending order.
- R4: Inside a module, the search for an SM starts at local SM 0 at each launch. After a grant to local SM s, the next search starts at s+1, wrapping around. An SM is eligible only if its `sm_avail` bit is 1 and it holds no CTA.
- R5: A module whose chunk is exhausted, or whose SMs are all unavailable, issues nothing. No other module takes over its indices.
- R6: In round-robin mode (`launch_mode`=1), at most one grant is issued per cycle, with indices 0, 1, 2 and so on. The SM is chosen by a rotating priority over the global SM ids g = m*SMS_PER_MOD + local. The search starts at g = 0 at launch and continues after the last granted SM. The grant appears on the lane of the owning module, and `gnt_sm` carries the local id.
- R7: A granted SM is busy until its `cta_done[g]` bit is 1 at a clock edge. A `cta_done` bit for an SM that holds no CTA has no effect on grants or on the completion of the kernel.
- R8: `kernel_done` is 1 for exactly one cycle. That cycle directly follows the cycle whose closing edge took the final completion, with the whole range already issued. For a count of 0, `kernel_done` is 1 in the second cycle after the accepting edge.
- R9: A launch is accepted at an edge where `launch_valid` and `launch_ready` are both 1. `launch_ready` is 0 from the accepting edge until the edge that raises `kernel_done`. A launch held during that time is accepted at the first edge after it.
- R10: The mode and count are taken at the accepting edge. Grants can begin in the cycle right after that edge, and later changes on `launch_mode` or `launch_count` do not affect the running kernel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| launch_valid | input | 1 | Launch request |
| launch_mode | input | 1 | 0 = contiguous groups per module, 1 = global round-robin |
| launch_count | input | CNT_W | Number of CTAs in the kernel |
| launch_ready | output | 1 | Scheduler idle; a launch is accepted |
| sm_avail | input | NUM_MOD*SMS_PER_MOD | SM may take work, indexed by global SM id |
| cta_done | input | NUM_MOD*SMS_PER_MOD | CTA on this SM finished, indexed by global SM id |
| gnt_vld | output | NUM_MOD | Dispatch valid per module lane |
| gnt_sm | output | NUM_MOD*SW | Local SM id per lane |
| gnt_cta | output | NUM_MOD*CNT_W | CTA index per lane |
| kernel_done | output | 1 | One-cycle pulse when the kernel has completed |

## Verification
The bench drives counts that divide evenly by the module count, counts that leave a remainder, and a count smaller than the module count. These separate correct chunk bounds from off-by-one placement of the extra CTAs. A count is launched twice to show that each index keeps its module. Sparse SM availability and per-SM completion latencies that differ tell a rotating arbiter apart from a fixed-priority one. Taking a whole module offline and bringing it back later shows that its range is neither stolen nor lost. Round-robin runs, with and without gaps in availability, show single-grant global rotation. Directed cases cover a stray completion on an idle SM, a launch held during a busy kernel, and a zero-count kernel.

// File: rtl/sched_pkg.sv
// Shared types for the CTA scheduler.
package sched_pkg;
    typedef enum logic {
        MODE_GROUP = 1'b0,
        MODE_RR    = 1'b1
    } sched_mode_e;
endpackage

// File: rtl/cta_rot_arb.sv
// Rotating-priority picker: returns the first set request at or after
// `start`, wrapping around. Assumes N is a power of two and N >= 2.
module cta_rot_arb #(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] start,
    output logic          hit,
    output logic [IW-1:0] pick
);
    logic [IW-1:0] cand;

    // Scan from the start position and keep the first requester found.
    always_comb begin
        hit  = 1'b0;
        pick = '0;
        cand = '0;
        for (int i = 0; i < N; i++) begin
            cand = start + IW'(i);
            if (!hit && req[cand]) begin
                hit  = 1'b1;
                pick = cand;
            end
        end
    end
endmodule

// File: rtl/cta_lane.sv
// One module's issue lane: walks a contiguous index chunk in ascending
// order and hands one index per cycle to a free local SM chosen by a
// rotating arbiter. Assumes SMS is a power of two, SMS >= 2.
module cta_lane #(
    parameter int SMS   = 4,
    parameter int CNT_W = 16,
    localparam int SW   = $clog2(SMS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] first,
    input  logic [CNT_W-1:0] len,
    input  logic             en,
    input  logic [SMS-1:0]   elig,
    output logic             gnt_vld,
    output logic [SW-1:0]    gnt_sm,
    output logic [CNT_W-1:0] gnt_cta,
    output logic             drained
);
    logic [CNT_W-1:0] cur_q;
    logic [CNT_W-1:0] left_q;
    logic [SW-1:0]    ptr_q;
    logic             hit;
    logic [SW-1:0]    pick;

    cta_rot_arb #(.N(SMS)) u_arb (
        .req   (elig),
        .start (ptr_q),
        .hit   (hit),
        .pick  (pick)
    );

    // Grant while the chunk has indices left and some SM is free.
    assign gnt_vld = en && (left_q != '0) && hit;
    assign gnt_sm  = pick;
    assign gnt_cta = cur_q;
    assign drained = (left_q == '0);

    // Chunk cursor and arbiter pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            left_q <= '0;
            ptr_q  <= '0;
        end else if (load) begin
            cur_q  <= first;
            left_q <= len;
            ptr_q  <= '0;
        end else if (gnt_vld) begin
            cur_q  <= cur_q + CNT_W'(1);
            left_q <= left_q - CNT_W'(1);
            ptr_q  <= pick + SW'(1);
        end
    end
endmodule

// File: rtl/cta_group_sched.sv
// Distributed CTA scheduler. Group mode splits the kernel's index range
// into one contiguous chunk per module; round-robin mode issues one CTA per
// cycle over all SMs. Each SM holds one CTA at a time. Assumes NUM_MOD and
// SMS_PER_MOD are powers of two, each >= 2.
module cta_group_sched
    import sched_pkg::*;
#(
    parameter int NUM_MOD     = 4,
    parameter int SMS_PER_MOD = 64,
    parameter int CNT_W       = 16,
    localparam int NUM_SM = NUM_MOD * SMS_PER_MOD,
    localparam int SW     = $clog2(SMS_PER_MOD)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     launch_valid,
    input  logic                     launch_mode,
    input  logic [CNT_W-1:0]         launch_count,
    output logic                     launch_ready,
    input  logic [NUM_SM-1:0]        sm_avail,
    input  logic [NUM_SM-1:0]        cta_done,
    output logic [NUM_MOD-1:0]       gnt_vld,
    output logic [NUM_MOD*SW-1:0]    gnt_sm,
    output logic [NUM_MOD*CNT_W-1:0] gnt_cta,
    output logic                     kernel_done
);
    localparam int MW = $clog2(NUM_MOD);
    localparam int GW = $clog2(NUM_SM);
    localparam int OW = GW + 1;

    sched_mode_e       mode_q;
    logic              active_q;
    logic              done_q;
    logic [OW-1:0]     out_q;
    logic [NUM_SM-1:0] busy_q;
    logic [CNT_W-1:0]  rr_next_q;
    logic [CNT_W-1:0]  rr_left_q;
    logic [GW-1:0]     rr_ptr_q;

    logic              accept;
    logic              finish;
    logic              issued_all;
    logic [NUM_SM-1:0] elig;
    logic [NUM_SM-1:0] take_sm;
    logic [OW-1:0]     n_take;
    logic [OW-1:0]     n_free;
    logic [CNT_W-1:0]  base;
    logic [MW-1:0]     rem;
    logic              rr_hit;
    logic [GW-1:0]     rr_pick;
    logic              rr_vld;

    logic [NUM_MOD-1:0] lane_vld;
    logic [NUM_MOD-1:0] lane_drained;
    logic [SW-1:0]      lane_sm  [NUM_MOD];
    logic [CNT_W-1:0]   lane_cta [NUM_MOD];

    assign launch_ready = !active_q;
    assign accept       = launch_valid && !active_q;
    assign kernel_done  = done_q;
    assign elig         = sm_avail & ~busy_q;
    assign base         = launch_count >> MW;
    assign rem          = launch_count[MW-1:0];

    // Global round-robin picker for the baseline mode.
    cta_rot_arb #(.N(NUM_SM)) u_rr_arb (
        .req   (elig),
        .start (rr_ptr_q),
        .hit   (rr_hit),
        .pick  (rr_pick)
    );
    assign rr_vld = active_q && (mode_q == MODE_RR) && (rr_left_q != '0) && rr_hit;

    // One issue lane per module, with its chunk bounds and the output mux.
    for (genvar g = 0; g < NUM_MOD; g++) begin : g_lane
        localparam logic [MW-1:0] GI = MW'(g);
        logic [CNT_W-1:0] c_first;
        logic [CNT_W-1:0] c_len;

        assign c_len   = base + ((GI < rem) ? CNT_W'(1) : CNT_W'(0));
        assign c_first = base * CNT_W'(g) + ((GI < rem) ? CNT_W'(g) : CNT_W'(rem));

        cta_lane #(.SMS(SMS_PER_MOD), .CNT_W(CNT_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (accept),
            .first   (c_first),
            .len     (c_len),
            .en      (active_q && (mode_q == MODE_GROUP)),
            .elig    (elig[g*SMS_PER_MOD +: SMS_PER_MOD]),
            .gnt_vld (lane_vld[g]),
            .gnt_sm  (lane_sm[g]),
            .gnt_cta (lane_cta[g]),
            .drained (lane_drained[g])
        );

        assign gnt_vld[g] = (mode_q == MODE_RR)
                          ? (rr_vld && (rr_pick[GW-1:SW] == GI)) : lane_vld[g];
        assign gnt_sm[g*SW +: SW] = (mode_q == MODE_RR) ? rr_pick[SW-1:0] : lane_sm[g];
        assign gnt_cta[g*CNT_W +: CNT_W] = (mode_q == MODE_RR) ? rr_next_q : lane_cta[g];
    end

    // Expand lane grants into a per-SM take vector.
    always_comb begin
        take_sm = '0;
        for (int m = 0; m < NUM_MOD; m++) begin
            for (int s = 0; s < SMS_PER_MOD; s++) begin
                if (gnt_vld[m] && (gnt_sm[m*SW +: SW] == SW'(s))) begin
                    take_sm[m*SMS_PER_MOD + s] = 1'b1;
                end
            end
        end
    end

    // Grant and completion counts, plus the end-of-kernel condition.
    always_comb begin
        n_take     = OW'($countones(take_sm));
        n_free     = OW'($countones(cta_done & busy_q));
        issued_all = (mode_q == MODE_RR) ? (rr_left_q == '0) : (&lane_drained);
        finish     = active_q && issued_all && (out_q == '0);
    end

    // Kernel state, SM occupancy and the round-robin cursor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_GROUP;
            active_q  <= 1'b0;
            done_q    <= 1'b0;
            out_q     <= '0;
            busy_q    <= '0;
            rr_next_q <= '0;
            rr_left_q <= '0;
            rr_ptr_q  <= '0;
        end else begin
            done_q <= finish;
            busy_q <= (busy_q & ~cta_done) | take_sm;
            out_q  <= out_q + n_take - n_free;
            if (accept) begin
                active_q  <= 1'b1;
                mode_q    <= sched_mode_e'(launch_mode);
                rr_next_q <= '0;
                rr_left_q <= launch_count;
                rr_ptr_q  <= '0;
            end else begin
                if (finish) begin
                    active_q <= 1'b0;
                end
                if (rr_vld) begin
                    rr_next_q <= rr_next_q + CNT_W'(1);
                    rr_left_q <= rr_left_q - CNT_W'(1);
                    rr_ptr_q  <= rr_pick + GW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/cta_group_sched_chk.sv
// Protocol checker for cta_group_sched, attached with bind below.
module cta_group_sched_chk #(
    parameter int NUM_MOD = 4,
    parameter int NUM_SM  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               launch_ready,
    input logic               kernel_done,
    input logic               mode_rr,
    input logic [NUM_MOD-1:0] gnt_vld,
    input logic [NUM_SM-1:0]  take_sm,
    input logic [NUM_SM-1:0]  busy,
    input logic [NUM_SM-1:0]  sm_avail
);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kernel_done |=> !kernel_done);

    // R9
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kernel_done |-> launch_ready);

    // R9
    idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch_ready |-> (gnt_vld == '0));

    // R6
    rr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_rr |-> $onehot0(gnt_vld));

    // R7
    grant_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_sm & (busy | ~sm_avail)) == '0);

    // R7
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_sm != '0) |=> ((busy & $past(take_sm)) == $past(take_sm)));
endmodule

bind cta_group_sched cta_group_sched_chk #(.NUM_MOD(NUM_MOD), .NUM_SM(NUM_SM)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch_ready (launch_ready),
    .kernel_done  (kernel_done),
    .mode_rr      (mode_q),
    .gnt_vld      (gnt_vld),
    .take_sm      (take_sm),
    .busy         (busy_q),
    .sm_avail     (sm_avail)
);

// File: tb/cta_group_sched_bench.sv
module cta_group_sched_bench;
    localparam int NM  = 4;
    localparam int SPM = 2;
    localparam int NS  = NM * SPM;
    localparam int CW  = 8;
    localparam int SW  = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          launch_valid = 1'b0;
    logic          launch_mode = 1'b0;
    logic [CW-1:0] launch_count = '0;
    logic          launch_ready;
    logic [NS-1:0] sm_avail = '1;
    logic [NS-1:0] cta_done = '0;
    logic [NM-1:0] gnt_vld;
    logic [NM*SW-1:0] gnt_sm;
    logic [NM*CW-1:0] gnt_cta;
    logic          kernel_done;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    cta_group_sched #(.NUM_MOD(NM), .SMS_PER_MOD(SPM), .CNT_W(CW)) u_cta_group_sched (
        .clk (clk), .rst_n (rst_n),
        .launch_valid (launch_valid), .launch_mode (launch_mode),
        .launch_count (launch_count), .launch_ready (launch_ready),
        .sm_avail (sm_avail), .cta_done (cta_done),
        .gnt_vld (gnt_vld), .gnt_sm (gnt_sm), .gnt_cta (gnt_cta),
        .kernel_done (kernel_done)
    );

    // Row: mode, count, avail before switch, avail after, switch cycle, lane-3 total.
    localparam logic [40:0] VEC [0:7] = '{
        {1'b0, 8'd16, 8'hFF, 8'hFF, 8'd255, 8'd4},
        {1'b0, 8'd13, 8'hFF, 8'hFF, 8'd255, 8'd3},
        {1'b0, 8'd13, 8'hFF, 8'hFF, 8'd255, 8'd3},
        {1'b1, 8'd11, 8'hFF, 8'hFF, 8'd255, 8'd0},
        {1'b0, 8'd3,  8'hFF, 8'hFF, 8'd255, 8'd0},
        {1'b1, 8'd5,  8'hA6, 8'hA6, 8'd255, 8'd0},
        {1'b0, 8'd20, 8'h5B, 8'h5B, 8'd255, 8'd5},
        {1'b0, 8'd8,  8'hFC, 8'hFF, 8'd24,  8'd2}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lat(input int s);
        return 2 + (s % 3);
    endfunction

    // Launch one kernel and follow it with a cycle model of the requirements.
    task automatic run_kernel(input bit md, input int cnt, input logic [7:0] av0,
                              input logic [7:0] av1, input int sw, input int exp_last);
        int  cur[NM]; int left[NM]; int ptr[NM]; int len0;
        bit  bz[NS]; int tm[NS]; bit drv[NS];
        int  rr_next; int rr_left; int rr_ptr; int outst; int lane3; int total;
        bit  act; bit prev_cond; bit seen;
        int  base; int rem;
        base = cnt / NM; rem = cnt % NM;
        for (int m = 0; m < NM; m++) begin
            left[m] = base + ((m < rem) ? 1 : 0);
            cur[m]  = m * base + ((m < rem) ? m : rem);
            ptr[m]  = 0;
        end
        len0 = left[0];
        for (int s = 0; s < NS; s++) begin bz[s] = 0; tm[s] = 0; drv[s] = 0; end
        rr_next = 0; rr_left = cnt; rr_ptr = 0; outst = 0; lane3 = 0; total = 0;
        act = 1; prev_cond = 0; seen = 0;
        @(negedge clk);
        sm_avail = av0; launch_valid = 1'b1; launch_mode = md; launch_count = CW'(cnt);
        check(launch_ready == 1'b1, "R9", int'(launch_ready), 1);
        @(negedge clk);
        launch_valid = 1'b0; launch_mode = ~md; launch_count = 8'd99;
        for (int cyc = 0; cyc < 400; cyc++) begin
            bit ev[NM]; int es[NM]; int ec[NM];
            if (cyc == sw) begin
                check(total == cnt - len0, "R5", total, cnt - len0);
                sm_avail = av1;
            end
            #1;
            for (int s = 0; s < NS; s++) begin
                if (drv[s]) begin bz[s] = 0; drv[s] = 0; outst--; end
            end
            cta_done = '0;
            check(kernel_done == prev_cond, "R8", int'(kernel_done), int'(prev_cond));
            if (kernel_done && prev_cond) begin seen = 1; break; end
            begin
                bit issued; bit cond;
                issued = md ? (rr_left == 0) : 1'b1;
                if (!md) for (int m = 0; m < NM; m++) if (left[m] != 0) issued = 0;
                cond = act && issued && (outst == 0);
                prev_cond = cond;
                if (cond) act = 0;
            end
            for (int s = 0; s < NS; s++) begin
                if (bz[s]) begin tm[s]--; if (tm[s] == 0) drv[s] = 1; end
            end
            for (int m = 0; m < NM; m++) begin ev[m] = 0; es[m] = 0; ec[m] = 0; end
            if (md) begin
                if (rr_left > 0) begin
                    for (int i = 0; i < NS; i++) begin
                        int s; s = (rr_ptr + i) % NS;
                        if (!ev[s / SPM] && sm_avail[s] && !bz[s] && (ev[0] | ev[1] | ev[2] | ev[3]) == 0) begin
                            ev[s / SPM] = 1; es[s / SPM] = s % SPM; ec[s / SPM] = rr_next;
                            rr_next++; rr_left--; rr_ptr = (s + 1) % NS;
                            bz[s] = 1; tm[s] = lat(s); outst++;
                        end
                    end
                end
            end else begin
                for (int m = 0; m < NM; m++) begin
                    if (left[m] > 0) begin
                        for (int i = 0; i < SPM; i++) begin
                            int l; int s; l = (ptr[m] + i) % SPM; s = m * SPM + l;
                            if (!ev[m] && sm_avail[s] && !bz[s]) begin
                                ev[m] = 1; es[m] = l; ec[m] = cur[m];
                                cur[m]++; left[m]--; ptr[m] = (l + 1) % SPM;
                                bz[s] = 1; tm[s] = lat(s); outst++;
                            end
                        end
                    end
                end
            end
            if (cyc == 0) check((gnt_vld != '0) == (cnt != 0), "R10", int'(gnt_vld != '0), int'(cnt != 0));
            for (int m = 0; m < NM; m++) begin
                check(gnt_vld[m] == ev[m], md ? "R6" : "R3", int'(gnt_vld[m]), int'(ev[m]));
                if (ev[m] && gnt_vld[m]) begin
                    total++;
                    if (m == NM - 1) lane3++;
                    check(int'(gnt_sm[m*SW +: SW]) == es[m], md ? "R6" : "R4", int'(gnt_sm[m*SW +: SW]), es[m]);
                    check(int'(gnt_cta[m*CW +: CW]) == ec[m], md ? "R6" : "R2", int'(gnt_cta[m*CW +: CW]), ec[m]);
                end
            end
            for (int s = 0; s < NS; s++) cta_done[s] = drv[s];
            @(negedge clk);
        end
        check(seen, "R8", int'(seen), 1);
        if (!md) check(lane3 == exp_last, "R2", lane3, exp_last);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(launch_ready == 1'b1, "R1", int'(launch_ready), 1);
        check(gnt_vld == '0, "R1", int'(gnt_vld), 0);
        check(kernel_done == 1'b0, "R1", int'(kernel_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(launch_ready == 1'b1 && gnt_vld == '0, "R1", int'(launch_ready), 1);

        for (int r = 0; r < 8; r++) begin
            run_kernel(VEC[r][40], int'(VEC[r][39:32]), VEC[r][31:24], VEC[r][23:16],
                       int'(VEC[r][15:8]), int'(VEC[r][7:0]));
        end

        // R7/R9: stray completion on an idle SM, launch held while busy
        sm_avail = '1;
        @(negedge clk);
        launch_valid = 1'b1; launch_mode = 1'b0; launch_count = 8'd1;
        @(negedge clk);
        launch_count = 8'd4;
        check(gnt_vld == 4'b0001, "R2", int'(gnt_vld), 1);
        check(gnt_cta[7:0] == 8'd0 && gnt_sm[0] == 1'b0, "R4", int'(gnt_cta[7:0]), 0);
        check(launch_ready == 1'b0, "R9", int'(launch_ready), 0);
        cta_done = 8'b0010_0000;
        @(negedge clk);
        cta_done = '0;
        check(gnt_vld == '0, "R3", int'(gnt_vld), 0);
        repeat (3) begin
            @(negedge clk);
            check(kernel_done == 1'b0, "R7", int'(kernel_done), 0);
            check(launch_ready == 1'b0, "R9", int'(launch_ready), 0);
        end
        cta_done = 8'b0000_0001;
        @(negedge clk);
        cta_done = '0;
        check(kernel_done == 1'b0, "R8", int'(kernel_done), 0);
        @(negedge clk);
        check(kernel_done == 1'b1, "R8", int'(kernel_done), 1);
        check(launch_ready == 1'b1, "R9", int'(launch_ready), 1);
        @(negedge clk);
        launch_valid = 1'b0;
        check(gnt_vld == 4'b1111, "R9", int'(gnt_vld), 15);
        for (int m = 0; m < NM; m++) begin
            check(int'(gnt_cta[m*CW +: CW]) == m, "R2", int'(gnt_cta[m*CW +: CW]), m);
        end
        check(kernel_done == 1'b0, "R8", int'(kernel_done), 0);
        @(negedge clk);
        cta_done = 8'b0101_0101;
        @(negedge clk);
        cta_done = '0;
        check(kernel_done == 1'b0, "R8", int'(kernel_done), 0);
        @(negedge clk);
        check(kernel_done == 1'b1, "R8", int'(kernel_done), 1);

        // R8: zero-count kernel
        @(negedge clk);
        launch_valid = 1'b1; launch_count = 8'd0;
        @(negedge clk);
        launch_valid = 1'b0;
        check(kernel_done == 1'b0 && gnt_vld == '0, "R8", int'(kernel_done), 0);
        @(negedge clk);
        check(kernel_done == 1'b1, "R8", int'(kernel_done), 1);
        @(negedge clk);
        check(kernel_done == 1'b0 && launch_ready == 1'b1, "R8", int'(kernel_done), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule